// File: doc/BRIEF.md
# Request-Paced Memory-to-Peripheral DMA Channel

This block is one DMA channel that copies 32-bit words from memory into a single peripheral, paced by that peripheral's requests. A session begins with a `start` strobe. The strobe loads the source pointer and the fixed destination address. The channel then spends one cycle clearing the peripheral's request state and waits for a request.

Each request carries a 2-bit kind and a final flag:

- A burst request copies 64 words, issued as sixteen groups of four beats.
- A single request copies one word.

The channel reads memory through a simple read port whose data arrives one cycle after the read enable. Each word returned is forwarded at once on a peripheral write port. The channel raises an acknowledge together with the last word of each request.

The source pointer advances by four bytes per word and carries on from one request to the next. When a request marked final has been served, the channel pulses `done` and returns to idle.

Top module: `pdma_channel`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `flush`, `mem_rd_en`, `pw_valid`, `pw_last`, `ack`, `done` and `err` are all low.
- R2: A `start` in idle gives `flush` high for exactly one cycle, in the cycle after the start edge. The channel then awaits requests. A request presented during that flush cycle is not served.
- R3: A request with kind 2'b01 moves 64 words. Read addresses advance by 4 from the current source pointer. Each word read is written to the fixed destination address, in order and unchanged, one cycle after its read.
- R4: During a 64-word transfer, `pw_last` is high on every fourth written beat (beats 3, 7, …, 63, counting from 0) and low on all others, giving 16 four-beat transactions.
- R5: A request with kind 2'b00 moves exactly one word, and `pw_last` is high on that beat.
- R6: `ack` is high only in the cycle that carries the final written word of a served request, and never otherwise.
- R7: The source pointer is loaded only by `start` and is not reset between requests, so each request continues where the previous one stopped.
- R8: A request raised while a transfer is in progress is ignored, including its final flag.
- R9: A request with kind 2'b10 or 2'b11 moves no data and sets `err`. `err` stays high until the next `start`.
- R10: When a request carrying the final flag is served, `done` pulses together with its `ack` and the channel goes idle. Later requests move no data until a new `start`.
- R11: `pw_valid` is high only in the cycle after a cycle with `mem_rd_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a session when the channel is idle |
| src_base | input | 32 | Source byte address loaded by `start` |
| dst_base | input | 32 | Destination address loaded by `start` |
| req_valid | input | 1 | Peripheral request strobe |
| req_kind | input | 2 | 2'b01 burst, 2'b00 single, other values invalid |
| req_final | input | 1 | Marks the last request of the session |
| flush | output | 1 | One-cycle clear of the peripheral's request state |
| mem_rd_en | output | 1 | Memory read enable |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rd_data | input | 32 | Read data, valid one cycle after `mem_rd_en` |
| pw_valid | output | 1 | Peripheral write beat valid |
| pw_addr | output | 32 | Peripheral write address (fixed in a session) |
| pw_data | output | 32 | Peripheral write data |
| pw_last | output | 1 | Last beat of a transaction |
| ack | output | 1 | Request completion acknowledge |
| done | output | 1 | Session finished pulse |
| err | output | 1 | Invalid request kind seen, sticky until `start` |

## Verification
The assertions take two things for granted:

- Memory always returns data exactly one cycle after a read, with no wait states.
- The peripheral accepts every write beat without pushing back.

The bench's memory model is a registered lookup that answers every read on the next edge, and it never stalls the write side. Requests are driven at falling edges and held for one cycle. Some are placed deliberately inside flush, transfer and idle windows, so that only the acceptance rules decide whether they are served.

// File: rtl/pdma_channel.sv
module pdma_channel #(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int BURST_WORDS = 64,
  parameter int TXN_BEATS   = 4,
  parameter int WORD_BYTES  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic          req_final,
  output logic          flush,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          pw_valid,
  output logic [AW-1:0] pw_addr,
  output logic [DW-1:0] pw_data,
  output logic          pw_last,
  output logic          ack,
  output logic          done,
  output logic          err
);
  localparam int CW = $clog2(BURST_WORDS + 1);
  localparam logic [CW-1:0] BURST_N = CW'(BURST_WORDS);
  localparam logic [CW-1:0] TMASK   = CW'(TXN_BEATS - 1);
  localparam logic [CW-1:0] ONE     = CW'(1);

  typedef enum logic [1:0] {S_IDLE, S_FLUSH, S_WAIT, S_RUN} st_t;
  st_t st;

  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt, total, wcnt;
  logic          wv, last_req;

  assign flush       = (st == S_FLUSH);
  assign mem_rd_en   = (st == S_RUN) && (cnt != total);
  assign mem_rd_addr = src;
  assign pw_valid    = wv;
  assign pw_addr     = dst;
  assign pw_data     = mem_rd_data;
  assign pw_last     = wv && ((total == ONE) || ((wcnt & TMASK) == TMASK));
  assign ack         = wv && (wcnt == total - ONE);
  assign done        = ack && last_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      src      <= '0;
      dst      <= '0;
      cnt      <= '0;
      total    <= '0;
      wcnt     <= '0;
      wv       <= 1'b0;
      last_req <= 1'b0;
      err      <= 1'b0;
    end else begin
      wv   <= mem_rd_en;
      wcnt <= cnt;
      if (mem_rd_en) begin
        src <= src + AW'(WORD_BYTES);
        cnt <= cnt + ONE;
      end
      case (st)
        S_IDLE: if (start) begin
          st  <= S_FLUSH;
          src <= src_base;
          dst <= dst_base;
          err <= 1'b0;
        end
        S_FLUSH: st <= S_WAIT;
        S_WAIT: if (req_valid) begin
          if (req_kind[1]) begin
            err <= 1'b1;
          end else begin
            total    <= req_kind[0] ? BURST_N : ONE;
            cnt      <= '0;
            last_req <= req_final;
            st       <= S_RUN;
          end
        end
        S_RUN: if (ack) st <= last_req ? S_IDLE : S_WAIT;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pdma_channel_chk.sv
module pdma_channel_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_rd_addr,
  input logic          pw_valid,
  input logic [AW-1:0] pw_addr,
  input logic          pw_last,
  input logic          ack,
  input logic          done
);
  assert_pipe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid |-> $past(mem_rd_en));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + AW'(4)));

  assert_dst_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_valid && $past(pw_valid)) |-> $stable(pw_addr));

  assert_ack_on_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (pw_valid && pw_last));

  assert_done_with_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ack);

  assert_flush_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  assert_no_read_in_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !mem_rd_en);
endmodule

bind pdma_channel pdma_channel_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .mem_rd_en(mem_rd_en),
  .mem_rd_addr(mem_rd_addr), .pw_valid(pw_valid), .pw_addr(pw_addr),
  .pw_last(pw_last), .ack(ack), .done(done)
);

// File: tb/tb_pdma_channel.sv
module tb_pdma_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] src_base = '0, dst_base = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic        req_final = 1'b0;
  logic        flush, mem_rd_en, pw_valid, pw_last, ack, done, err;
  logic [31:0] mem_rd_addr, pw_addr, pw_data;
  logic [31:0] mem_rd_data = '0;

  pdma_channel dut (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  int beat = 0, writes = 0, exp_total = 1;
  logic [31:0] exp_src = '0, exp_dst = '0;
  bit cur_final = 0, finished = 0;

  function automatic logic [31:0] fm(input logic [31:0] a);
    return (a * 32'h0000_9E37) ^ 32'h5A5A_1234;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= fm(mem_rd_addr);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (pw_valid) begin
      chk(pw_data == fm(exp_src), "R3 data", pw_data, fm(exp_src));
      chk(pw_addr == exp_dst, "R3 dst", pw_addr, exp_dst);
      if (exp_total == 1) chk(pw_last == 1'b1, "R5 last", pw_last, 1);
      else chk(pw_last == ((beat % 4) == 3), "R4 last", pw_last, ((beat % 4) == 3));
      chk(ack == (beat == exp_total - 1), "R6 ack", ack, (beat == exp_total - 1));
      chk(done == ((beat == exp_total - 1) && cur_final), "R10 done", done,
          ((beat == exp_total - 1) && cur_final));
      exp_src = exp_src + 4;
      writes++;
      beat++;
      if (beat == exp_total) beat = 0;
    end else if (ack || done) begin
      chk(1'b0, "R6 stray ack", {ack, done}, 0);
    end
  end

  task automatic begin_session(input logic [31:0] s, input logic [31:0] d, input bit poke);
    int w0;
    @(negedge clk);
    start = 1; src_base = s; dst_base = d; exp_src = s; exp_dst = d;
    @(negedge clk);
    start = 0;
    chk(flush == 1'b1, "R2 flush high", flush, 1);
    chk(err == 1'b0, "R9 err cleared by start", err, 0);
    w0 = writes;
    if (poke) begin req_valid = 1; req_kind = 2'b00; req_final = 1; end
    @(negedge clk);
    req_valid = 0; req_final = 0;
    chk(flush == 1'b0, "R2 flush one cycle", flush, 0);
    repeat (4) @(negedge clk);
    chk(writes == w0, "R2 request in flush ignored", writes, w0);
  endtask

  task automatic serve(input logic [1:0] kind, input bit fin, input bit inject);
    int w0;
    @(negedge clk);
    w0 = writes;
    exp_total = (kind == 2'b01) ? 64 : 1;
    cur_final = fin;
    req_valid = 1; req_kind = kind; req_final = fin;
    @(negedge clk);
    req_valid = 0; req_final = 0;
    if (inject) begin
      repeat (10) @(negedge clk);
      req_valid = 1; req_kind = 2'b00; req_final = 1;
      @(negedge clk);
      req_valid = 0; req_final = 0;
    end
    for (int i = 0; i < 300 && (writes - w0) < exp_total; i++) @(negedge clk);
    @(negedge clk);
    chk((writes - w0) == exp_total, kind == 2'b01 ? "R3 burst count" : "R5 single count",
        writes - w0, exp_total);
  endtask

  task automatic bad_req(input logic [1:0] kind);
    int w0;
    @(negedge clk);
    w0 = writes;
    req_valid = 1; req_kind = kind; req_final = 1;
    @(negedge clk);
    req_valid = 0; req_final = 0;
    repeat (4) @(negedge clk);
    chk(err == 1'b1, "R9 err set", err, 1);
    chk(writes == w0, "R9 no transfer", writes, w0);
  endtask

  task automatic idle_probe();
    int w0;
    w0 = writes;
    @(negedge clk);
    req_valid = 1; req_kind = 2'b01; req_final = 0;
    repeat (2) @(negedge clk);
    req_valid = 0;
    repeat (6) @(negedge clk);
    chk(writes == w0, "R10 idle after final", writes, w0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({flush, mem_rd_en, pw_valid, pw_last, ack, done, err} == 7'b0, "R1 in reset",
        {flush, mem_rd_en, pw_valid, pw_last, ack, done, err}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({flush, mem_rd_en, pw_valid, pw_last, ack, done, err} == 7'b0, "R1 after reset",
        {flush, mem_rd_en, pw_valid, pw_last, ack, done, err}, 0);

    begin_session(32'h0000_1000, 32'h4000_0010, 1'b1);
    bad_req(2'b10);
    bad_req(2'b11);
    serve(2'b00, 0, 0);
    serve(2'b01, 0, 1);           // R8: single+final injected mid-burst
    serve(2'b00, 0, 0);           // R8: still running after the injected request
    serve(2'b00, 0, 0);           // R7: pointer continues
    serve(2'b01, 1, 0);
    idle_probe();

    begin_session(32'h0000_0080, 32'h4000_0200, 1'b0);
    for (int i = 0; i < 9; i++)
      serve((i % 3 == 0) ? 2'b01 : 2'b00, i == 8, 0);
    idle_probe();

    begin_session(32'h00FF_FFF0, 32'h4000_0300, 1'b0);
    serve(2'b00, 1, 0);
    idle_probe();

    finish_run();
  end
endmodule